// File: doc/BRIEF.md
# Motion Sensor Indexed Register Window

This block is the device-side model of a motion sensor's host interface. The host sees only two byte-wide locations. Port 0 selects a register number. Port 1 reads or writes the register that is selected. Behind this pair sit the following:

- a command/status register;
- a lock flag;
- a record-count byte;
- a snapshot buffer of up to five acceleration records, each five bytes long;
- a ready byte that reports whether the buffer may be released.

Readings arrive on a valid-qualified sample input and collect in an internal queue of `QDEPTH` entries. When the queue is full, the oldest entry is dropped. Any nonzero command keeps the block busy for `BUSY_CYCLES` clock cycles. The capture command copies the queue into the snapshot when it completes. Configuration commands only show busy and leave the snapshot as it is.

Top module: `motion_regwin`

## Requirements
- R1: A write strobe with `bus_port`=0 loads the register index. A strobe with `bus_port`=1 accesses the register at that index, and the index does not advance. A read strobe updates `bus_rdata` on the next clock edge: with port 0 it returns the index, and with port 1 it returns the selected register.
- R2: A nonzero byte written to register 0x00 while idle starts a command. Data-port reads of 0x00 made on each of the next `BUSY_CYCLES` clock edges return that byte, and later reads return 0x00. Writing 0x00 starts nothing.
- R3: A write to register 0x00 while a command is busy is ignored. The running command's code and its effect are kept.
- R4: Register 0x01 is the lock. Writing 0xFF sets it and writing 0x00 clears it. Any other value leaves it unchanged. It reads 0xFF when set and 0x00 when clear.
- R5: Each cycle with `smp_valid` high appends one record to a queue of `QDEPTH` (5) entries. When a sample arrives at a full queue, the oldest entry is discarded.
- R6: The capture command (0x11) moves the queue into the snapshot when it completes, oldest record first. Record r, byte b sits at register 0x11+5r+b, in this byte order: X[7:0], X[15:8], Y[7:0], Y[15:8], extra. Record slots that are not filled read 0x00. Register 0x10 takes the record count (0..5), and the queue is emptied.
- R7: The snapshot bytes and the count change only when a capture completes. Configuration commands (any other nonzero code) leave them unchanged. A capture is accepted whether or not the lock is set.
- R8: Register 0x10 may also be written by the host and reads back the written byte. Writes to the snapshot bytes 0x11..0x29 are ignored.
- R9: Register 0x2F reads 0x80 while a command is busy and 0x00 when idle.
- R10: Reads of unmapped registers return 0x00, and writes to them have no effect.
- R11: After reset the index and every register read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_rd | input | 1 | Host read strobe, one cycle |
| bus_port | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Registered read byte, valid the cycle after `bus_rd` |
| smp_valid | input | 1 | New sample present |
| smp_x | input | 16 | Sample X axis |
| smp_y | input | 16 | Sample Y axis |
| smp_extra | input | 8 | Sample extra byte |

## Verification
The assertions check several rules on every cycle:

- an accepted command is busy on the next cycle with the written code;
- a write made while busy does not alter the running code;
- a 0xFF write sets the lock;
- the queue never exceeds its depth;
- the snapshot holds still except on the cycle after a capture completes.

Other behaviour only the bench scenarios can show: the exact busy length seen through polling, the byte layout and oldest-first order of records, the drop-oldest overflow rule, the zero fill of empty slots, and the ignored writes to read-only and unmapped registers. These scenarios compare full register read-backs against a queue model kept in the bench.

// File: rtl/motion_regwin_pkg.sv
package motion_regwin_pkg;
  typedef struct packed {
    logic [15:0] x;
    logic [15:0] y;
    logic [7:0]  extra;
  } accel_rec_t;

  localparam int         REC_BYTES  = 5;
  localparam logic [7:0] A_CMD      = 8'h00;
  localparam logic [7:0] A_LOCK     = 8'h01;
  localparam logic [7:0] A_COUNT    = 8'h10;
  localparam logic [7:0] A_REC0     = 8'h11;
  localparam logic [7:0] A_READY    = 8'h2F;
  localparam logic [7:0] CMD_CAPT   = 8'h11;
  localparam logic [7:0] LOCK_HOLD  = 8'hFF;
  localparam logic [7:0] LOCK_FREE  = 8'h00;
  localparam logic [7:0] BUSY_FLAG  = 8'h80;
endpackage

// File: rtl/motion_sample_queue.sv
module motion_sample_queue
  import motion_regwin_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push,
  input  accel_rec_t              rec_in,
  input  logic                    flush,
  output accel_rec_t [DEPTH-1:0]  entries,
  output logic [CW-1:0]           count
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      entries <= '0;
      count   <= '0;
    end else if (flush) begin
      // Empty the queue; a sample arriving in the same cycle is kept.
      entries <= '0;
      if (push) begin
        entries[0] <= rec_in;
        count      <= CW'(1);
      end else begin
        count <= '0;
      end
    end else if (push) begin
      if (count < FULL) begin
        entries[count] <= rec_in;
        count          <= count + CW'(1);
      end else begin
        for (int i = 0; i < DEPTH - 1; i++) entries[i] <= entries[i+1];
        entries[DEPTH-1] <= rec_in;
      end
    end
  end
endmodule

// File: rtl/motion_cmd_timer.sv
module motion_cmd_timer #(
  parameter int BUSY_CYCLES = 6,
  localparam int TW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] start_code,
  output logic       busy,
  output logic [7:0] cur_code,
  output logic       done
);
  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain   <= '0;
      cur_code <= '0;
    end else if (start && !busy) begin
      remain   <= TW'(BUSY_CYCLES);
      cur_code <= start_code;
    end else if (busy) begin
      remain <= remain - TW'(1);
      if (done) cur_code <= '0;
    end
  end

  assign busy = (remain != '0);
  assign done = (remain == TW'(1));
endmodule

// File: rtl/motion_snapshot.sv
module motion_snapshot
  import motion_regwin_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int NBYTES = DEPTH * REC_BYTES,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  accel_rec_t [DEPTH-1:0]  recs,
  input  logic [CW-1:0]           rec_count,
  input  logic                    host_we,
  input  logic [7:0]              host_data,
  input  logic [7:0]              rd_off,
  output logic [7:0]              rd_byte,
  output logic [7:0]              count_q,
  output logic [NBYTES*8-1:0]     snap_flat
);
  logic [7:0] mem [NBYTES];

  for (genvar r = 0; r < DEPTH; r++) begin : g_rec
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int b = 0; b < REC_BYTES; b++) mem[r*REC_BYTES+b] <= '0;
      end else if (load) begin
        mem[r*REC_BYTES+0] <= recs[r].x[7:0];
        mem[r*REC_BYTES+1] <= recs[r].x[15:8];
        mem[r*REC_BYTES+2] <= recs[r].y[7:0];
        mem[r*REC_BYTES+3] <= recs[r].y[15:8];
        mem[r*REC_BYTES+4] <= recs[r].extra;
      end
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_flat
    assign snap_flat[i*8 +: 8] = mem[i];
  end

  always_ff @(posedge clk) begin
    if (rst)          count_q <= '0;
    else if (load)    count_q <= 8'(rec_count);
    else if (host_we) count_q <= host_data;
  end

  always_comb begin
    rd_byte = '0;
    if (rd_off < 8'(NBYTES)) rd_byte = mem[rd_off];
  end
endmodule

// File: rtl/motion_regwin.sv
module motion_regwin
  import motion_regwin_pkg::*;
#(
  parameter int QDEPTH      = 5,
  parameter int BUSY_CYCLES = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_port,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        smp_valid,
  input  logic [15:0] smp_x,
  input  logic [15:0] smp_y,
  input  logic [7:0]  smp_extra
);
  localparam int NBYTES = QDEPTH * REC_BYTES;
  localparam int CW     = $clog2(QDEPTH + 1);
  localparam logic [7:0] A_RECN = A_REC0 + 8'(NBYTES) - 8'd1;

  logic [7:0] idx_q;
  logic       lock_q;
  logic       data_wr;
  logic       accept;
  logic       busy;
  logic       done;
  logic       cap_load;
  logic [7:0] cur_code;
  logic [7:0] snap_byte;
  logic [7:0] count_q;
  logic [7:0] rd_val;
  logic [CW-1:0] q_count;
  logic [NBYTES*8-1:0] snap_flat;
  accel_rec_t [QDEPTH-1:0] q_entries;
  accel_rec_t smp_rec;

  assign data_wr  = bus_wr && bus_port;
  assign accept   = data_wr && (idx_q == A_CMD) && (bus_wdata != 8'h00) && !busy;
  assign cap_load = done && (cur_code == CMD_CAPT);
  assign smp_rec  = '{x: smp_x, y: smp_y, extra: smp_extra};

  motion_sample_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(smp_valid), .rec_in(smp_rec),
    .flush(cap_load), .entries(q_entries), .count(q_count)
  );

  motion_cmd_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(accept), .start_code(bus_wdata),
    .busy(busy), .cur_code(cur_code), .done(done)
  );

  motion_snapshot #(.DEPTH(QDEPTH)) u_snap (
    .clk(clk), .rst(rst), .load(cap_load), .recs(q_entries),
    .rec_count(q_count),
    .host_we(data_wr && (idx_q == A_COUNT)), .host_data(bus_wdata),
    .rd_off(idx_q - A_REC0), .rd_byte(snap_byte), .count_q(count_q),
    .snap_flat(snap_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      lock_q <= 1'b0;
    end else if (bus_wr) begin
      if (!bus_port) idx_q <= bus_wdata;
      else if (idx_q == A_LOCK) begin
        if (bus_wdata == LOCK_HOLD)      lock_q <= 1'b1;
        else if (bus_wdata == LOCK_FREE) lock_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (idx_q == A_CMD)                          rd_val = busy ? cur_code : 8'h00;
    else if (idx_q == A_LOCK)                    rd_val = lock_q ? LOCK_HOLD : LOCK_FREE;
    else if (idx_q == A_COUNT)                   rd_val = count_q;
    else if (idx_q == A_READY)                   rd_val = busy ? BUSY_FLAG : 8'h00;
    else if (idx_q >= A_REC0 && idx_q <= A_RECN) rd_val = snap_byte;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= bus_port ? rd_val : idx_q;
  end
endmodule

// File: rtl/motion_regwin_chk.sv
module motion_regwin_chk #(
  parameter int QDEPTH = 5,
  localparam int NBYTES = QDEPTH * 5,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_port,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        idx_q,
  input logic              accept,
  input logic              busy,
  input logic              done,
  input logic [7:0]        cur_code,
  input logic              lock_q,
  input logic              cap_load,
  input logic [CW-1:0]     q_count,
  input logic [NBYTES*8-1:0] snap_flat
);
  p_cmd_accept_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && cur_code == $past(bus_wdata)));

  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && bus_wr && bus_port && idx_q == 8'h00) |=> (cur_code == $past(cur_code)));

  p_lock_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_port && idx_q == 8'h01 && bus_wdata == 8'hFF) |=> lock_q);

  p_queue_bound_r5: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(QDEPTH));

  p_snap_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !cap_load |=> $stable(snap_flat));
endmodule

bind motion_regwin motion_regwin_chk #(.QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_port(bus_port),
  .bus_wdata(bus_wdata), .idx_q(idx_q), .accept(accept), .busy(busy),
  .done(done), .cur_code(cur_code), .lock_q(lock_q), .cap_load(cap_load),
  .q_count(q_count), .snap_flat(snap_flat)
);

// File: tb/test_motion_regwin.sv
module test_motion_regwin;
  localparam int QD = 5;
  localparam int BUSY = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, bus_port = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic smp_valid = 0;
  logic [15:0] smp_x = 0, smp_y = 0;
  logic [7:0] smp_extra = 0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench model of queue and snapshot
  logic [15:0] mx [QD], my [QD], sx [QD], sy [QD];
  logic [7:0]  me [QD], se [QD];
  int mcnt = 0;
  int scnt = 0;

  always #4 clk = ~clk;

  motion_regwin #(.QDEPTH(QD), .BUSY_CYCLES(BUSY)) i_motion_regwin (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y), .smp_extra(smp_extra)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic p, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_port = p; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bread(input logic p, output logic [7:0] v);
    @(negedge clk); bus_rd = 1; bus_port = p;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [7:0] v);
    bwrite(0, a);
    bread(1, v);
  endtask

  task automatic push(input logic [15:0] x, input logic [15:0] y, input logic [7:0] e);
    @(negedge clk); smp_valid = 1; smp_x = x; smp_y = y; smp_extra = e;
    @(negedge clk); smp_valid = 0;
    if (mcnt < QD) begin
      mx[mcnt] = x; my[mcnt] = y; me[mcnt] = e; mcnt++;
    end else begin
      for (int i = 0; i < QD - 1; i++) begin mx[i] = mx[i+1]; my[i] = my[i+1]; me[i] = me[i+1]; end
      mx[QD-1] = x; my[QD-1] = y; me[QD-1] = e;
    end
  endtask

  function automatic logic [7:0] exp_byte(input int r, input int b);
    if (r >= scnt) return 8'h00;
    case (b)
      0: return sx[r][7:0];
      1: return sx[r][15:8];
      2: return sy[r][7:0];
      3: return sy[r][15:8];
      default: return se[r];
    endcase
  endfunction

  function automatic void model_capture();
    scnt = mcnt;
    for (int i = 0; i < QD; i++) begin
      sx[i] = (i < mcnt) ? mx[i] : 16'h0;
      sy[i] = (i < mcnt) ? my[i] : 16'h0;
      se[i] = (i < mcnt) ? me[i] : 8'h0;
    end
    mcnt = 0;
  endfunction

  // Issue a command and poll register 0 every cycle; checks R2 busy length.
  task automatic run_cmd(input logic [7:0] code, input string req);
    int n;
    bwrite(0, 8'h00);
    bwrite(1, code);
    bus_rd = 1; bus_port = 1;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (bus_rdata == 8'h00) break;
      if (n == 0) chk({req, " first poll"}, bus_rdata, code);
      n++;
    end
    bus_rd = 0;
    chk({req, " busy polls"}, 8'(n), 8'(BUSY));
    if (code == 8'h11) model_capture();
  endtask

  task automatic verify_snapshot(input string req);
    logic [7:0] v;
    rdreg(8'h10, v); chk({req, " count"}, v, 8'(scnt));
    for (int r = 0; r < QD; r++)
      for (int b = 0; b < 5; b++) begin
        rdreg(8'h11 + 8'(r * 5 + b), v);
        chk(req, v, exp_byte(r, b));
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int seed;
    seed = $urandom(32'h1234ABCD);
    repeat (3) @(negedge clk);
    rst = 0;

    // R11: reset state
    bread(0, v);      chk("R11 index", v, 8'h00);
    rdreg(8'h00, v);  chk("R11 cmd", v, 8'h00);
    rdreg(8'h01, v);  chk("R11 lock", v, 8'h00);
    rdreg(8'h10, v);  chk("R11 count", v, 8'h00);
    rdreg(8'h2F, v);  chk("R11 ready", v, 8'h00);
    rdreg(8'h11, v);  chk("R11 rec", v, 8'h00);

    // R1: index readback, no auto increment
    bwrite(0, 8'h37); bread(0, v); chk("R1 index read", v, 8'h37);
    bread(1, v); bread(0, v); chk("R1 no increment", v, 8'h37);

    // R10: unmapped
    bwrite(0, 8'h05); bwrite(1, 8'hA5); bread(1, v); chk("R10 unmapped", v, 8'h00);
    rdreg(8'h2A, v); chk("R10 beyond records", v, 8'h00);

    // R4: lock
    bwrite(0, 8'h01); bwrite(1, 8'hFF); bread(1, v); chk("R4 set", v, 8'hFF);
    bwrite(1, 8'h5A); bread(1, v); chk("R4 other ignored", v, 8'hFF);
    bwrite(1, 8'h00); bread(1, v); chk("R4 release", v, 8'h00);

    // R2: zero write starts nothing
    bwrite(0, 8'h00); bwrite(1, 8'h00); bread(1, v); chk("R2 zero no start", v, 8'h00);
    rdreg(8'h2F, v); chk("R9 idle after zero", v, 8'h00);

    // R8: host count write
    bwrite(0, 8'h10); bwrite(1, 8'hC8); bread(1, v); chk("R8 count write", v, 8'hC8);

    // R6/R7: empty capture with lock clear
    run_cmd(8'h11, "R2 capture empty");
    verify_snapshot("R6 empty");

    // R5/R6: overflow drops oldest
    for (int i = 0; i < 8; i++) push(16'h1000 + 16'(i), 16'h2000 + 16'(i * 3), 8'(8'h40 + i));
    bwrite(0, 8'h01); bwrite(1, 8'hFF);
    run_cmd(8'h11, "R5 capture");
    verify_snapshot("R5 overflow order");

    // R8: snapshot bytes read-only
    bwrite(0, 8'h11); bwrite(1, 8'hEE); bread(1, v); chk("R8 rec read-only", v, exp_byte(0, 0));

    // R9: ready byte while busy
    bwrite(0, 8'h00); bwrite(1, 8'h17);
    bwrite(0, 8'h2F); bread(1, v); chk("R9 busy", v, 8'h80);
    repeat (BUSY + 2) @(negedge clk);
    bread(1, v); chk("R9 idle", v, 8'h00);

    // R3/R7: config busy, capture during busy ignored, snapshot kept
    push(16'hBEEF, 16'hCAFE, 8'h99);
    bwrite(0, 8'h00); bwrite(1, 8'h14); bwrite(1, 8'h11);
    bread(1, v); chk("R3 code kept", v, 8'h14);
    repeat (BUSY + 2) @(negedge clk);
    verify_snapshot("R7 config keeps snapshot");
    run_cmd(8'h10, "R7 config");
    verify_snapshot("R7 config again");

    // R6: random rounds, lock random
    for (int rnd = 0; rnd < 20; rnd++) begin
      int n;
      n = int'($urandom_range(0, 8));
      for (int i = 0; i < n; i++) push(16'($urandom), 16'($urandom), 8'($urandom));
      bwrite(0, 8'h01); bwrite(1, ($urandom_range(0, 1) != 0) ? 8'hFF : 8'h00);
      run_cmd(8'h11, "R6 random capture");
      verify_snapshot("R6 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule